// File: doc/BRIEF.md
# Windowed Watchdog Timer

The block is a watchdog counter with a small register interface. Once enabled, it counts clock cycles up from zero. Software services it by writing a two-byte unlock key to the kick register. A correct key restarts the count. The block checks the count against four programmable thresholds, each a power of two:
- a late limit that flags an interrupt;
- a late limit that flags a system reset;
- an early limit for the interrupt;
- an early limit for the reset.

The two early limits are checked only when window mode is on. Service that arrives before an early limit is then treated as a fault.

The block has four sticky event flags, which software clears by writing ones to them. The interrupt output is a level. The reset request output is a single-cycle pulse. A 3-bit clock-select field drives an output port so that an external multiplexer can pick the counter clock. The multiplexer itself, clock-switch handshaking and clock-domain crossing are not part of this block. The whole block runs on one clock.

Register offsets (byte addresses) are as follows:
- 0x0 is the control register (read and write).
- 0x4 is the kick register (write only).
- 0x8 is the clock select (read and write).
- 0xC is the count (read only).

Read data is registered, so it appears one cycle after the address is presented.

Top module: `windowed_watchdog`

## Requirements
- R1: After reset the control register, clock select and count all read 0, and `irq` and `rst_req` are 0.
- R2: A threshold code k (4 bits) selects 2^(MAX_EXP-k) cycles. With the default MAX_EXP of 31, code 0 is 2^31 and code 15 is 2^16.
- R3: The count restarts at 0 only after a write of 0xA5 and then a write of 0x5A to offset 0x4. Any other kick value written after 0xA5 cancels the sequence. Writes to other offsets in between do not cancel it.
- R4: Control bit 9 (late-interrupt flag) is set on the cycle after the count equals the late-interrupt threshold, which is held in bits 3:0. `irq` equals bit 10 (interrupt enable) ANDed with (bit 9 OR bit 12), one cycle after the flags.
- R5: Control bit 31 (late-reset flag) is set when the count equals the late-reset threshold, held in bits 7:4. If bit 11 (reset enable) is 1, `rst_req` pulses high for exactly one cycle on the same edge.
- R6: When bit 29 (window mode) is 1, a completed kick whose count is below the early-interrupt threshold (bits 19:16) sets bit 12. A completed kick whose count is below the early-reset threshold (bits 23:20) sets bit 30 and, with bit 11 set, pulses `rst_req` on the kick edge.
- R7: When bit 29 is 0, an early kick sets neither bit 12 nor bit 30 and requests no reset.
- R8: While bit 8 (enable) is 0, the count stays at 0 and no flag, `irq` or `rst_req` is produced. Enabling starts the count from 0 on the enabling write edge.
- R9: Flag bits 9, 12, 30 and 31 are sticky. Writing 1 clears a flag. Writing 0 leaves it unchanged.
- R10: The count at 0xC reads as cycles elapsed since the last restart, and writes to 0xC have no effect. The clock select at 0x8 bits 2:0 reads back and drives `clk_sel`.
- R11: The count saturates instead of wrapping, so each late event fires at most once per service period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter and register clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for `bus_addr` |
| irq | output | 1 | Level interrupt request |
| rst_req | output | 1 | Single-cycle system reset request |
| clk_sel | output | 3 | Clock source selection for an external multiplexer |

## Verification
The bench uses a small configuration (MAX_EXP = 19) so that every threshold code from 12 to 15 can be swept to its exact edge.

It checks each threshold one cycle before and at the cycle it fires. A design that compared with >= or was off by one on the counter's start value would fire a cycle early or late.

The early checks kick at exactly one count below and one count at each early threshold. This catches a `<=` compare, or a compare that uses the cleared count instead of the count at the kick.

Broken and interleaved unlock sequences show whether the key machine resets on a wrong value and stays armed across unrelated writes. Flag write-zero, repeated late periods and disabled-mode stimulus show lost stickiness, repeated firing and events leaking out while disabled.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int DATA_W  = 32;
  localparam int CODE_W  = 4;
  localparam int CSEL_W  = 3;
  localparam int NUM_THR = 4;

  // threshold / event index
  localparam int T_LATE_IRQ  = 0;
  localparam int T_LATE_RST  = 1;
  localparam int T_EARLY_IRQ = 2;
  localparam int T_EARLY_RST = 3;

  // register byte offsets
  localparam int OFS_CTRL = 'h0;
  localparam int OFS_KICK = 'h4;
  localparam int OFS_CSEL = 'h8;
  localparam int OFS_CNT  = 'hC;

  localparam logic [7:0] KEY_FIRST  = 8'hA5;
  localparam logic [7:0] KEY_SECOND = 8'h5A;

  // control register bit positions
  localparam int B_LI     = 0;
  localparam int B_LR     = 4;
  localparam int B_RUN    = 8;
  localparam int B_F_LI   = 9;
  localparam int B_IRQ_EN = 10;
  localparam int B_RST_EN = 11;
  localparam int B_F_EI   = 12;
  localparam int B_EI     = 16;
  localparam int B_ER     = 20;
  localparam int B_WIN    = 29;
  localparam int B_F_ER   = 30;
  localparam int B_F_LR   = 31;

  typedef logic [NUM_THR-1:0] evt_t;

  typedef struct packed {
    logic win;
    logic rst_en;
    logic irq_en;
    logic run;
    logic [NUM_THR-1:0][CODE_W-1:0] code;
  } cfg_t;

  typedef enum logic {KEY_IDLE, KEY_ARMED} key_st_t;
endpackage

// File: rtl/wdt_unlock.sv
module wdt_unlock
  import wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr,
  input  logic       sel,
  input  logic [7:0] data,
  output logic       kick
);
  key_st_t st;
  logic    key_wr;

  assign key_wr = wr && sel;
  assign kick   = key_wr && (st == KEY_ARMED) && (data == KEY_SECOND);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= KEY_IDLE;
    end else if (key_wr) begin
      if (data == KEY_FIRST) st <= KEY_ARMED;
      else                   st <= KEY_IDLE;
    end
  end

  // R3: the armed state is only entered through a first-key write
  p_arm_by_key_r3: assert property (@(posedge clk) disable iff (rst)
    (st == KEY_ARMED && $past(st) == KEY_IDLE) |-> $past(key_wr && data == KEY_FIRST));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int MAX_EXP = 31,
  parameter int CNT_W   = MAX_EXP + 1
)(
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           run,
  input  logic                           win,
  input  logic                           kick,
  input  logic [NUM_THR-1:0][CODE_W-1:0] codes,
  output logic [CNT_W-1:0]               count,
  output evt_t                           evt
);
  localparam logic [CNT_W-1:0] CNT_TOP = '1;
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic [CNT_W-1:0] thr [NUM_THR];

  generate
    for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
      assign thr[t] = ONE << (MAX_EXP - int'(codes[t]));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || !run || kick) count <= '0;
    else if (count != CNT_TOP) count <= count + ONE;
  end

  always_comb begin
    evt              = '0;
    evt[T_LATE_IRQ]  = run && (count == thr[T_LATE_IRQ]);
    evt[T_LATE_RST]  = run && (count == thr[T_LATE_RST]);
    evt[T_EARLY_IRQ] = run && win && kick && (count < thr[T_EARLY_IRQ]);
    evt[T_EARLY_RST] = run && win && kick && (count < thr[T_EARLY_RST]);
  end

  // R8: disabled counter is held at zero
  p_hold_off_r8: assert property (@(posedge clk) disable iff (rst)
    !run |=> count == '0);
  // R3: a completed key restarts the count
  p_restart_r3: assert property (@(posedge clk) disable iff (rst)
    kick |=> count == '0);
  // R11: no wrap back to zero without a restart
  p_no_wrap_r11: assert property (@(posedge clk) disable iff (rst)
    (run && !kick && count != '0) |=> count != '0);
  // R11: a late event lasts a single cycle
  p_late_once_r11: assert property (@(posedge clk) disable iff (rst)
    evt[T_LATE_IRQ] |=> !evt[T_LATE_IRQ]);
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 4
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  evt_t              evt,
  input  logic [CNT_W-1:0]  count,
  output cfg_t              cfg,
  output logic [CSEL_W-1:0] csel,
  output logic [DATA_W-1:0] rdata,
  output logic              irq,
  output logic              rst_req
);
  evt_t              flags, clr;
  logic              ctrl_wr, csel_wr;
  logic [DATA_W-1:0] ctrl_view, rd_mux;
  logic              unused_bits;

  assign unused_bits = ^{wdata[15:13], wdata[28:24]};
  assign ctrl_wr = wr && (addr == ADDR_W'(OFS_CTRL));
  assign csel_wr = wr && (addr == ADDR_W'(OFS_CSEL));

  always_comb begin
    clr              = '0;
    clr[T_LATE_IRQ]  = ctrl_wr && wdata[B_F_LI];
    clr[T_LATE_RST]  = ctrl_wr && wdata[B_F_LR];
    clr[T_EARLY_IRQ] = ctrl_wr && wdata[B_F_EI];
    clr[T_EARLY_RST] = ctrl_wr && wdata[B_F_ER];
  end

  always_comb begin
    ctrl_view                  = '0;
    ctrl_view[B_LI +: CODE_W]  = cfg.code[T_LATE_IRQ];
    ctrl_view[B_LR +: CODE_W]  = cfg.code[T_LATE_RST];
    ctrl_view[B_EI +: CODE_W]  = cfg.code[T_EARLY_IRQ];
    ctrl_view[B_ER +: CODE_W]  = cfg.code[T_EARLY_RST];
    ctrl_view[B_RUN]           = cfg.run;
    ctrl_view[B_IRQ_EN]        = cfg.irq_en;
    ctrl_view[B_RST_EN]        = cfg.rst_en;
    ctrl_view[B_WIN]           = cfg.win;
    ctrl_view[B_F_LI]          = flags[T_LATE_IRQ];
    ctrl_view[B_F_LR]          = flags[T_LATE_RST];
    ctrl_view[B_F_EI]          = flags[T_EARLY_IRQ];
    ctrl_view[B_F_ER]          = flags[T_EARLY_RST];
  end

  always_comb begin
    rd_mux = '0;
    if (addr == ADDR_W'(OFS_CTRL))      rd_mux = ctrl_view;
    else if (addr == ADDR_W'(OFS_CSEL)) rd_mux = DATA_W'(csel);
    else if (addr == ADDR_W'(OFS_CNT))  rd_mux = DATA_W'(count);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg     <= '0;
      flags   <= '0;
      csel    <= '0;
      rdata   <= '0;
      irq     <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        cfg.code[T_LATE_IRQ]  <= wdata[B_LI +: CODE_W];
        cfg.code[T_LATE_RST]  <= wdata[B_LR +: CODE_W];
        cfg.code[T_EARLY_IRQ] <= wdata[B_EI +: CODE_W];
        cfg.code[T_EARLY_RST] <= wdata[B_ER +: CODE_W];
        cfg.run               <= wdata[B_RUN];
        cfg.irq_en            <= wdata[B_IRQ_EN];
        cfg.rst_en            <= wdata[B_RST_EN];
        cfg.win               <= wdata[B_WIN];
      end
      if (csel_wr) csel <= wdata[CSEL_W-1:0];
      flags   <= (flags & ~clr) | evt;
      irq     <= cfg.irq_en && (flags[T_LATE_IRQ] || flags[T_EARLY_IRQ]);
      rst_req <= cfg.rst_en && (evt[T_LATE_RST] || evt[T_EARLY_RST]);
      rdata   <= rd_mux;
    end
  end

  // R5: every reset request is backed by a recorded reset flag
  p_rst_has_cause_r5: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> (flags[T_LATE_RST] || flags[T_EARLY_RST]));
  // R9: a set flag survives any write that does not clear it
  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (flags[T_LATE_IRQ] && !clr[T_LATE_IRQ]) |=> flags[T_LATE_IRQ]);
  // R7: without window mode the early flags never rise
  p_compat_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (!cfg.win && !flags[T_EARLY_IRQ] && !flags[T_EARLY_RST])
      |=> !(flags[T_EARLY_IRQ] || flags[T_EARLY_RST]));
endmodule

// File: rtl/windowed_watchdog.sv
module windowed_watchdog
  import wdt_pkg::*;
#(
  parameter int MAX_EXP = 31,
  parameter int ADDR_W  = 4
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic              rst_req,
  output logic [2:0]        clk_sel
);
  localparam int CNT_W = MAX_EXP + 1;

  cfg_t             cfg;
  evt_t             evt;
  logic             kick, kick_sel;
  logic [CNT_W-1:0] count;

  assign kick_sel = (bus_addr == ADDR_W'(OFS_KICK));

  wdt_unlock u_unlock (
    .clk  (clk),
    .rst  (rst),
    .wr   (bus_wr),
    .sel  (kick_sel),
    .data (bus_wdata[7:0]),
    .kick (kick)
  );

  wdt_counter #(.MAX_EXP(MAX_EXP), .CNT_W(CNT_W)) u_counter (
    .clk   (clk),
    .rst   (rst),
    .run   (cfg.run),
    .win   (cfg.win),
    .kick  (kick),
    .codes (cfg.code),
    .count (count),
    .evt   (evt)
  );

  wdt_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr      (bus_wr),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .evt     (evt),
    .count   (count),
    .cfg     (cfg),
    .csel    (clk_sel),
    .rdata   (bus_rdata),
    .irq     (irq),
    .rst_req (rst_req)
  );
endmodule

// File: tb/test_windowed_watchdog.sv
module test_windowed_watchdog;
  localparam int MAX_EXP = 19;
  localparam logic [3:0] A_CTRL = 4'h0, A_KICK = 4'h4, A_CSEL = 4'h8, A_CNT = 4'hC;
  localparam logic [31:0] FLAG_ALL = 32'hC000_1200;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, rst_req;
  logic [2:0]  clk_sel;

  int checks = 0, fails = 0, ecnt = 0, k_edge = 0, pulses = 0;
  bit done = 0;

  windowed_watchdog #(.MAX_EXP(MAX_EXP), .ADDR_W(4)) i_windowed_watchdog (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .rst_req(rst_req), .clk_sel(clk_sel));

  always #5 clk = ~clk;
  always @(posedge clk) ecnt <= ecnt + 1;
  always @(negedge clk) if (!rst && rst_req) pulses <= pulses + 1;

  function automatic int thr(input int code);
    return 1 << (MAX_EXP - code);
  endfunction

  function automatic logic [31:0] cw(input int li, lr, ei, er,
                                     input bit en, ie, re, win);
    logic [31:0] w = '0;
    w[3:0] = li[3:0]; w[7:4] = lr[3:0]; w[19:16] = ei[3:0]; w[23:20] = er[3:0];
    w[8] = en; w[10] = ie; w[11] = re; w[29] = win;
    return w;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic wait_to(input int t);
    while (ecnt < t) @(negedge clk);
  endtask

  task automatic kick();
    wr_reg(A_KICK, 32'hA5);
    wr_reg(A_KICK, 32'h5A);
    k_edge = ecnt;
  endtask

  // complete a kick when the count equals c
  task automatic kick_at(input int c);
    wait_to(k_edge + c - 1);
    kick();
  endtask

  task automatic enable(input logic [31:0] w);
    wr_reg(A_CTRL, w | FLAG_ALL);
    k_edge = ecnt;
  endtask

  task automatic stop_all();
    wr_reg(A_CTRL, FLAG_ALL);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL all watchdog expired act=0x0 exp=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int p0, w0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd_reg(A_CTRL, d); chk(d == 0, "R1 ctrl", d, 0);
    rd_reg(A_CNT, d);  chk(d == 0, "R1 count", d, 0);
    rd_reg(A_CSEL, d); chk(d == 0, "R1 csel", d, 0);
    chk(irq == 0 && rst_req == 0, "R1 outputs", {irq, rst_req}, 0);

    // R10 clock select
    wr_reg(A_CSEL, 32'hFFFF_FFF5);
    rd_reg(A_CSEL, d); chk(d == 5, "R10 csel readback", d, 5);
    chk(clk_sel == 5, "R10 clk_sel port", clk_sel, 5);

    // R8 disabled: nothing happens
    p0 = pulses;
    wr_reg(A_CTRL, cw(15, 15, 0, 0, 0, 1, 1, 0));
    repeat (100) @(negedge clk);
    rd_reg(A_CNT, d); chk(d == 0, "R8 count held", d, 0);
    rd_reg(A_CTRL, d); chk((d & FLAG_ALL) == 0, "R8 no flags", d & FLAG_ALL, 0);
    chk(irq == 0, "R8 irq", irq, 0);
    chk(pulses == p0, "R8 rst_req", pulses, p0);

    // R2/R4 late-interrupt sweep over codes 12..15
    for (int code = 12; code <= 15; code++) begin
      enable(cw(code, 0, 0, 0, 1, 1, 0, 0));
      wait_to(k_edge + thr(code) + 1);
      chk(irq == 0, $sformatf("R2 code %0d before", code), irq, 0);
      wait_to(k_edge + thr(code) + 2);
      chk(irq == 1, $sformatf("R4 code %0d at thr", code), irq, 1);
      rd_reg(A_CTRL, d); chk(d[9] == 1, "R4 late irq flag", d[9], 1);
      stop_all();
      chk(irq == 0, "R4 irq after clear", irq, 0);
    end

    // R10 count readback, writes to count ignored
    enable(cw(0, 0, 0, 0, 1, 0, 0, 0));
    for (int i = 0; i < 4; i++) begin
      repeat (i * 7) @(negedge clk);
      rd_reg(A_CNT, d);
      chk(d == ecnt - 1 - k_edge, "R10 count value", d, ecnt - 1 - k_edge);
      wr_reg(A_CNT, 32'h0);
    end
    stop_all();

    // R5 late reset pulse timing, R11 once per period
    p0 = pulses;
    enable(cw(0, 15, 0, 0, 1, 0, 1, 0));
    wait_to(k_edge + thr(15));
    chk(rst_req == 0, "R5 before thr", rst_req, 0);
    wait_to(k_edge + thr(15) + 1);
    chk(rst_req == 1, "R5 at thr", rst_req, 1);
    wait_to(k_edge + thr(15) + 2);
    chk(rst_req == 0, "R5 single cycle", rst_req, 0);
    wait_to(k_edge + 300);
    chk(pulses == p0 + 1, "R11 one late reset", pulses, p0 + 1);
    rd_reg(A_CTRL, d); chk(d[31] == 1, "R5 late rst flag", d[31], 1);
    stop_all();

    // R3 valid kick restarts
    enable(cw(15, 0, 0, 0, 1, 1, 0, 0));
    w0 = k_edge;
    kick_at(10);
    wait_to(w0 + 18);
    chk(irq == 0, "R3 kick moved deadline", irq, 0);
    wait_to(k_edge + 17); chk(irq == 0, "R3 new deadline before", irq, 0);
    wait_to(k_edge + 18); chk(irq == 1, "R3 new deadline", irq, 1);
    stop_all();

    // R3 broken sequence does not restart
    enable(cw(15, 0, 0, 0, 1, 1, 0, 0));
    w0 = k_edge;
    wait_to(w0 + 2);
    wr_reg(A_KICK, 32'hA5); wr_reg(A_KICK, 32'h00); wr_reg(A_KICK, 32'h5A);
    wait_to(w0 + 17); chk(irq == 0, "R3 broken before", irq, 0);
    wait_to(w0 + 18); chk(irq == 1, "R3 broken no restart", irq, 1);
    stop_all();

    // R3 unrelated write between keys keeps the sequence
    enable(cw(15, 0, 0, 0, 1, 1, 0, 0));
    w0 = k_edge;
    wr_reg(A_KICK, 32'hA5); wr_reg(A_CSEL, 32'h3); wr_reg(A_KICK, 32'h5A);
    k_edge = ecnt;
    chk(clk_sel == 3, "R10 clk_sel update", clk_sel, 3);
    wait_to(w0 + 18); chk(irq == 0, "R3 interleaved restart", irq, 0);
    wait_to(k_edge + 18); chk(irq == 1, "R3 interleaved deadline", irq, 1);
    stop_all();

    // R6 window mode boundaries: early irq 64, early reset 32
    enable(cw(12, 12, 13, 14, 1, 1, 1, 1));
    p0 = pulses;
    kick_at(63);
    chk(rst_req == 0, "R6 c63 no rst", rst_req, 0);
    rd_reg(A_CTRL, d);
    chk(d[12] == 1 && d[30] == 0, "R6 c63 flags", {d[30], d[12]}, 2'b01);
    wr_reg(A_CTRL, cw(12, 12, 13, 14, 1, 1, 1, 1) | FLAG_ALL);
    kick_at(64);
    rd_reg(A_CTRL, d);
    chk(d[12] == 0 && d[30] == 0, "R6 c64 in window", {d[30], d[12]}, 0);
    kick_at(31);
    chk(rst_req == 1, "R6 c31 rst pulse", rst_req, 1);
    rd_reg(A_CTRL, d);
    chk(d[12] == 1 && d[30] == 1, "R6 c31 flags", {d[30], d[12]}, 2'b11);
    chk(rst_req == 0, "R6 c31 pulse ends", rst_req, 0);
    wr_reg(A_CTRL, cw(12, 12, 13, 14, 1, 1, 1, 1) | FLAG_ALL);
    kick_at(32);
    chk(rst_req == 0, "R6 c32 no rst", rst_req, 0);
    rd_reg(A_CTRL, d);
    chk(d[12] == 1 && d[30] == 0, "R6 c32 flags", {d[30], d[12]}, 2'b01);
    chk(pulses == p0 + 1, "R6 pulse count", pulses, p0 + 1);

    // R7 compatibility mode: early kick is fine
    wr_reg(A_CTRL, cw(12, 12, 13, 14, 1, 1, 1, 0) | FLAG_ALL);
    kick();
    p0 = pulses;
    kick_at(5);
    rd_reg(A_CTRL, d);
    chk(d[12] == 0 && d[30] == 0, "R7 no early flags", {d[30], d[12]}, 0);
    chk(pulses == p0 && irq == 0, "R7 no outputs", {pulses[7:0], irq}, {p0[7:0], 1'b0});
    stop_all();

    // R9 write-zero keeps, write-one clears; R11 no re-fire
    enable(cw(15, 0, 0, 0, 1, 0, 0, 0));
    wait_to(k_edge + 30);
    rd_reg(A_CTRL, d); chk(d[9] == 1, "R9 flag set", d[9], 1);
    chk(irq == 0, "R4 irq gated by enable", irq, 0);
    wr_reg(A_CTRL, cw(15, 0, 0, 0, 1, 0, 0, 0));
    rd_reg(A_CTRL, d); chk(d[9] == 1, "R9 write zero keeps", d[9], 1);
    wr_reg(A_CTRL, cw(15, 0, 0, 0, 1, 0, 0, 0) | 32'h200);
    rd_reg(A_CTRL, d); chk(d[9] == 0, "R9 write one clears", d[9], 0);
    repeat (200) @(negedge clk);
    rd_reg(A_CTRL, d); chk(d[9] == 0, "R11 no second late event", d[9], 0);
    stop_all();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule